// File: doc/BRIEF.md
# Channel Group Scheduler for a Sampling Converter

This block owns a small set of channel-group slots for a successive-approximation converter and decides which slot drives the converter at any moment. Each slot holds a 5-bit input channel selector and an interrupt enable. Each slot also has its own result register and its own completion flag. The converter's sequencer sees one active channel, a one-cycle start command and a one-cycle abort command. It answers with a done strobe and the converted data.

Two trigger regimes are supported. In software mode, a write to slot 0 queues a conversion, and writes to other slots only update their settings. In hardware mode, one trigger line per slot queues a conversion for that slot, and writes never queue anything. Requests that arrive while the converter is busy are held, and are granted lowest-index-first once it goes idle. A write to the slot currently converting cancels that conversion. A write to any other slot leaves the running conversion alone.

Top module: `pp_group_sched`

## Requirements
- R1: At most one group is active. A queued request produces a one-cycle `start` pulse on the second clock edge after the request is sampled, provided the converter was idle. `busy` is then high and `act_grp` names the granted group until done or abort.
- R2: With `hw_mode`=0, a write to group 0 queues a conversion for group 0. Writes to groups 1 and up never start one, and `hw_trig` has no effect.
- R3: With `hw_mode`=1, a one-cycle high on `hw_trig[g]` queues a conversion for group g, and slot writes never start a conversion.
- R4: A write to a group other than the active one during a conversion raises no `abort`, keeps `busy` high and leaves `act_grp` unchanged.
- R5: A write to the active group raises `abort` for one cycle after the write edge and drops `busy`. No result is stored. In software mode, such a write to group 0 restarts group 0 with the new channel.
- R6: `act_chan` equals the channel field of the active group's slot, over the full range 0 to 31.
- R7: `conv_done` while busy stores `conv_data` into the active group's result register and sets bit g of `coco`, where g is the active group's index, on the next edge. It also clears `busy`.
- R8: `irq` is high exactly when some group has both its `coco` bit and its interrupt enable set.
- R9: When `dma_en` is 1, a completed conversion raises `dma_req` for one cycle, in the same cycle its `coco` bit rises. When `dma_en` is 0, `dma_req` stays low.
- R10: With `rd_en`=1, `rd_data` shows the result register of `rd_grp` in the same cycle. The group's `coco` bit clears on that edge, unless a completion for the same group lands on that edge.
- R11: When several groups are pending at once, the lowest index is granted first. The others remain pending and are granted in turn as the converter becomes idle.
- R12: After reset, `busy`, `start`, `abort`, `dma_req`, `irq` and all `coco` bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Slot write strobe |
| wr_grp | input | 2 | Group index being written |
| wr_chan | input | 5 | Channel selector written to the slot |
| wr_ie | input | 1 | Interrupt enable written to the slot |
| hw_mode | input | 1 | 1 = hardware trigger mode, 0 = software mode |
| hw_trig | input | 4 | Per-group hardware trigger pulses |
| dma_en | input | 1 | Enables DMA request on completion |
| conv_done | input | 1 | Conversion finished strobe from the sequencer |
| conv_data | input | 12 | Converted value accompanying `conv_done` |
| rd_en | input | 1 | Result read strobe, clears that group's complete flag |
| rd_grp | input | 2 | Group whose result is read |
| rd_data | output | 12 | Result register of `rd_grp` |
| act_chan | output | 5 | Channel of the active group |
| act_grp | output | 2 | Index of the active group |
| busy | output | 1 | A conversion is in progress |
| start | output | 1 | One-cycle start command to the sequencer |
| abort | output | 1 | One-cycle abort command to the sequencer |
| coco | output | 4 | Per-group conversion complete flags, bit g for group g |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The hardest state to reach from the ports is a backlog of several pending groups that are drained one at a time while the scheduler is busy. To build it, the stimulus raises three trigger lines in the same cycle in hardware mode. It then completes each conversion in turn and checks that the grants come in index order, with the flags collecting one by one. Abort is exercised both in hardware mode, where it must not be followed by a restart, and in software mode, where it must be followed by an immediate restart of group 0 on the new channel. A scoreboard queue holds the expected group and channel of every start pulse, so any extra or missing start is reported.

// File: rtl/pp_sched_pkg.sv
package pp_sched_pkg;
  localparam int CHAN_W = 5;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              ie;
  } grp_slot_t;
endpackage

// File: rtl/pp_rst_sync.sv
module pp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_sync = sr_q[1];
endmodule

// File: rtl/pp_grp_arbiter.sv
module pp_grp_arbiter #(
  parameter int NG = 4,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic [NG-1:0] pend,
  output logic          gnt_vld,
  output logic [GW-1:0] gnt_idx
);
  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int i = NG - 1; i >= 0; i--) begin
      if (pend[i]) begin
        gnt_vld = 1'b1;
        gnt_idx = GW'(i);
      end
    end
  end
endmodule

// File: rtl/pp_grp_bank.sv
module pp_grp_bank
  import pp_sched_pkg::*;
#(
  parameter int NG    = 4,
  parameter int RES_W = 12,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [GW-1:0]    wr_grp,
  input  grp_slot_t        wr_slot,
  input  logic             done_ok,
  input  logic [GW-1:0]    done_grp,
  input  logic [RES_W-1:0] res_in,
  input  logic             rd_en,
  input  logic [GW-1:0]    rd_grp,
  output grp_slot_t        slots [NG],
  output logic [RES_W-1:0] rd_data,
  output logic [NG-1:0]    coco
);
  logic [RES_W-1:0] res_arr [NG];

  for (genvar g = 0; g < NG; g++) begin : g_slot
    grp_slot_t        s_q, s_d;
    logic [RES_W-1:0] r_q, r_d;
    logic             c_q, c_d;
    logic             wr_hit, st_hit, rd_hit;

    assign wr_hit = wr_en   && (wr_grp   == GW'(g));
    assign st_hit = done_ok && (done_grp == GW'(g));
    assign rd_hit = rd_en   && (rd_grp   == GW'(g));

    always_comb begin
      s_d = s_q;
      r_d = r_q;
      c_d = c_q;
      if (wr_hit) s_d = wr_slot;
      if (st_hit) begin
        r_d = res_in;
        c_d = 1'b1;
      end else if (rd_hit) begin
        c_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        r_q <= '0;
        c_q <= 1'b0;
      end else begin
        if (wr_hit)           s_q <= s_d;
        if (st_hit)           r_q <= r_d;
        if (st_hit || rd_hit) c_q <= c_d;
      end
    end

    assign slots[g]   = s_q;
    assign res_arr[g] = r_q;
    assign coco[g]    = c_q;
  end

  assign rd_data = res_arr[rd_grp];

  a_r7_flag_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> coco[$past(done_grp)]);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(done_ok && done_grp == rd_grp)) |=> !coco[$past(rd_grp)]);
endmodule

// File: rtl/pp_conv_ctrl.sv
module pp_conv_ctrl #(
  parameter int NG = 4,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_mode,
  input  logic [NG-1:0] hw_trig,
  input  logic          wr_en,
  input  logic [GW-1:0] wr_grp,
  input  logic          conv_done,
  input  logic          dma_en,
  output logic          busy,
  output logic [GW-1:0] act_grp,
  output logic          start,
  output logic          abort,
  output logic          dma_req,
  output logic          done_ok,
  output logic [GW-1:0] done_grp
);
  logic [NG-1:0] pend_q, pend_d;
  logic          busy_q, busy_d;
  logic [GW-1:0] act_q, act_d;
  logic          start_q, start_d;
  logic          abort_q, abort_d;
  logic          dma_q, dma_d;
  logic          gnt_vld;
  logic [GW-1:0] gnt_idx;
  logic          hit_active;

  pp_grp_arbiter #(.NG(NG)) u_arb (
    .pend    (pend_q),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  assign hit_active = wr_en && busy_q && (wr_grp == act_q);
  assign done_ok    = busy_q && conv_done && !hit_active;
  assign done_grp   = act_q;

  always_comb begin
    pend_d  = pend_q;
    busy_d  = busy_q;
    act_d   = act_q;
    start_d = 1'b0;
    abort_d = 1'b0;
    dma_d   = 1'b0;

    if (!busy_q && gnt_vld) begin
      busy_d          = 1'b1;
      act_d           = gnt_idx;
      start_d         = 1'b1;
      pend_d[gnt_idx] = 1'b0;
    end

    if (hit_active) begin
      busy_d  = 1'b0;
      abort_d = 1'b1;
    end else if (done_ok) begin
      busy_d = 1'b0;
      dma_d  = dma_en;
    end

    if (hw_mode) pend_d = pend_d | hw_trig;
    else if (wr_en && wr_grp == '0) pend_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      busy_q  <= 1'b0;
      act_q   <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      dma_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      busy_q  <= busy_d;
      start_q <= start_d;
      abort_q <= abort_d;
      dma_q   <= dma_d;
      if (start_d) act_q <= act_d;
    end
  end

  assign busy    = busy_q;
  assign act_grp = act_q;
  assign start   = start_q;
  assign abort   = abort_q;
  assign dma_req = dma_q;

  a_r4_foreign_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en && wr_grp != act_q && !conv_done)
      |=> (busy_q && !abort_q && act_q == $past(act_q)));

  a_r5_abort_from_active_write: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> $past(wr_en && busy_q && wr_grp == act_q));

  a_r9_dma_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> $past(conv_done && dma_en && busy_q));

  a_r1_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (busy_q && !abort_q));
endmodule

// File: rtl/pp_group_sched.sv
module pp_group_sched
  import pp_sched_pkg::*;
#(
  parameter int NG    = 4,
  parameter int RES_W = 12,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GW-1:0]     wr_grp,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              wr_ie,
  input  logic              hw_mode,
  input  logic [NG-1:0]     hw_trig,
  input  logic              dma_en,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              rd_en,
  input  logic [GW-1:0]     rd_grp,
  output logic [RES_W-1:0]  rd_data,
  output logic [CHAN_W-1:0] act_chan,
  output logic [GW-1:0]     act_grp,
  output logic              busy,
  output logic              start,
  output logic              abort,
  output logic [NG-1:0]     coco,
  output logic              irq,
  output logic              dma_req
);
  logic          rst_ns;
  grp_slot_t     wr_slot;
  grp_slot_t     slots [NG];
  logic          done_ok;
  logic [GW-1:0] done_grp;
  logic [NG-1:0] ie_vec;

  pp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  assign wr_slot.chan = wr_chan;
  assign wr_slot.ie   = wr_ie;

  pp_conv_ctrl #(.NG(NG)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_ns),
    .hw_mode   (hw_mode),
    .hw_trig   (hw_trig),
    .wr_en     (wr_en),
    .wr_grp    (wr_grp),
    .conv_done (conv_done),
    .dma_en    (dma_en),
    .busy      (busy),
    .act_grp   (act_grp),
    .start     (start),
    .abort     (abort),
    .dma_req   (dma_req),
    .done_ok   (done_ok),
    .done_grp  (done_grp)
  );

  pp_grp_bank #(.NG(NG), .RES_W(RES_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_ns),
    .wr_en    (wr_en),
    .wr_grp   (wr_grp),
    .wr_slot  (wr_slot),
    .done_ok  (done_ok),
    .done_grp (done_grp),
    .res_in   (conv_data),
    .rd_en    (rd_en),
    .rd_grp   (rd_grp),
    .slots    (slots),
    .rd_data  (rd_data),
    .coco     (coco)
  );

  for (genvar g = 0; g < NG; g++) begin : g_ie
    assign ie_vec[g] = slots[g].ie;
  end

  assign act_chan = slots[act_grp].chan;
  assign irq      = |(coco & ie_vec);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_ns)
    irq |-> (coco != '0));
endmodule

// File: tb/sim_pp_group_sched.sv
module sim_pp_group_sched;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_grp;
  logic [4:0]  wr_chan;
  logic        wr_ie;
  logic        hw_mode;
  logic [3:0]  hw_trig;
  logic        dma_en;
  logic        conv_done;
  logic [11:0] conv_data;
  logic        rd_en;
  logic [1:0]  rd_grp;
  logic [11:0] rd_data;
  logic [4:0]  act_chan;
  logic [1:0]  act_grp;
  logic        busy, start, abort, irq, dma_req;
  logic [3:0]  coco;

  int total = 0;
  int bad   = 0;
  logic [6:0] exp_q [$];

  always #10 clk = ~clk;

  pp_group_sched u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp), .wr_chan(wr_chan),
    .wr_ie(wr_ie), .hw_mode(hw_mode), .hw_trig(hw_trig), .dma_en(dma_en),
    .conv_done(conv_done), .conv_data(conv_data), .rd_en(rd_en), .rd_grp(rd_grp),
    .rd_data(rd_data), .act_chan(act_chan), .act_grp(act_grp), .busy(busy),
    .start(start), .abort(abort), .coco(coco), .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] g, input logic [4:0] ch, input logic ie);
    @(negedge clk);
    wr_en = 1'b1; wr_grp = g; wr_chan = ch; wr_ie = ie;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic trig(input logic [3:0] m);
    @(negedge clk);
    hw_trig = m;
    @(negedge clk);
    hw_trig = '0;
  endtask

  task automatic done(input logic [11:0] d);
    @(negedge clk);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic rd(input logic [1:0] g, input logic [11:0] exp);
    @(negedge clk);
    rd_en = 1'b1; rd_grp = g;
    #1 chk("R10 read data", rd_data, exp);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 flag cleared by read", coco[g], 0);
  endtask

  // scoreboard monitor: every start pulse must match the next expected grant
  always @(negedge clk) begin
    if (rst_n && start) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R1 unexpected start actual=%0h expected=none", {act_grp, act_chan});
      end else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        if ({act_grp, act_chan} != e) begin
          bad++;
          $display("FAIL R1/R6/R11 start grant actual=%0h expected=%0h", {act_grp, act_chan}, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_grp = 0; wr_chan = 0; wr_ie = 0; hw_mode = 0;
    hw_trig = 0; dma_en = 0; conv_done = 0; conv_data = 0; rd_en = 0; rd_grp = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    chk("R12 busy after reset", busy, 0);
    chk("R12 coco after reset", coco, 0);
    chk("R12 irq after reset", irq, 0);
    chk("R12 dma_req after reset", dma_req, 0);

    // software start on group 0
    exp_q.push_back({2'd0, 5'd7});
    wr(2'd0, 5'd7, 1'b0);
    cyc(2);
    chk("R2 group 0 write starts", busy, 1);
    chk("R6 act_chan", act_chan, 7);
    done(12'h123);
    chk("R7 coco bit 0", coco, 4'b0001);
    chk("R7 busy clears on done", busy, 0);
    chk("R9 no dma when disabled", dma_req, 0);
    rd(2'd0, 12'h123);

    // software mode: upper groups and triggers never start
    wr(2'd2, 5'd5, 1'b0);
    cyc(4);
    chk("R2 upper group write no start", busy, 0);
    trig(4'b0010);
    cyc(4);
    chk("R2 hw_trig ignored in sw mode", busy, 0);

    // hardware mode
    @(negedge clk); hw_mode = 1'b1;
    wr(2'd1, 5'd31, 1'b1);
    cyc(3);
    chk("R3 write no start in hw mode", busy, 0);
    exp_q.push_back({2'd1, 5'd31});
    trig(4'b0010);
    cyc(2);
    chk("R3 trigger starts group 1", busy, 1);
    chk("R6 act_chan 31", act_chan, 31);
    wr(2'd3, 5'd9, 1'b0);
    chk("R4 no abort on other group", abort, 0);
    chk("R4 still busy", busy, 1);
    chk("R4 active group kept", act_grp, 1);
    @(negedge clk); dma_en = 1'b1;
    done(12'hABC);
    chk("R7 coco bit 1", coco[1], 1);
    chk("R9 dma pulse", dma_req, 1);
    chk("R8 irq with enable", irq, 1);
    cyc(1);
    chk("R9 dma one cycle", dma_req, 0);
    rd(2'd1, 12'hABC);
    chk("R8 irq drops after read", irq, 0);

    // abort by writing the active group in hw mode
    exp_q.push_back({2'd2, 5'd5});
    trig(4'b0100);
    cyc(2);
    wr(2'd2, 5'd6, 1'b0);
    chk("R5 abort pulse", abort, 1);
    chk("R5 busy drops", busy, 0);
    cyc(4);
    chk("R5 no restart in hw mode", busy, 0);
    chk("R5 no result flag", coco, 0);

    // simultaneous triggers: lowest first
    exp_q.push_back({2'd1, 5'd31});
    exp_q.push_back({2'd2, 5'd6});
    exp_q.push_back({2'd3, 5'd9});
    trig(4'b1110);
    cyc(2);
    chk("R11 lowest granted", act_grp, 1);
    done(12'h001);
    cyc(2);
    chk("R11 next pending granted", act_grp, 2);
    done(12'h002);
    cyc(2);
    chk("R11 last pending granted", act_grp, 3);
    done(12'h003);
    chk("R7 flags collected", coco, 4'b1110);
    rd(2'd2, 12'h002);
    rd(2'd3, 12'h003);
    rd(2'd1, 12'h001);

    // software mode abort-and-restart of group 0
    @(negedge clk); hw_mode = 1'b0;
    exp_q.push_back({2'd0, 5'd3});
    wr(2'd0, 5'd3, 1'b0);
    cyc(2);
    exp_q.push_back({2'd0, 5'd4});
    wr(2'd0, 5'd4, 1'b0);
    chk("R5 sw abort pulse", abort, 1);
    cyc(2);
    chk("R5 sw restart busy", busy, 1);
    chk("R5 sw restart channel", act_chan, 4);
    done(12'h055);
    rd(2'd0, 12'h055);

    cyc(3);
    chk("R1 all expected starts seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule